// File: doc/BRIEF.md
# IDE DMA Chunk Transfer Sequencer

This block follows a single IDE DMA transfer from start to finish while a descriptor-driven DMA engine supplies the host memory as a series of chunks. A start pulse arms the transfer. It loads the number of bytes still owed and sets the running byte index to zero. For a hard disk that byte count is the sector count times 512. For an optical (packet) drive it is the packet transfer size. While armed, the block works through each chunk, given as an address and a length, in turn. It turns the chunk into a storage-side request that carries the medium byte offset, the memory address, the length and an operation code. It waits for the storage side to report done. It then updates its counters and decides whether the chunk, or the whole transfer, is finished.

Some decisions are made as each chunk is evaluated. A chunk that arrives while the sequencer is not armed is returned unprocessed, and the DMA channel must restart it later. When no bytes are owed, the transfer ends: a disk raises its drive interrupt and shows ready-and-seek-complete status, and an optical drive signals command OK. A zero-length chunk closes the chunk and leaves the counters alone. Optical data that has no block address is served as a single copy out of the internal buffer. A storage error ends the transfer, with an error kind that depends on the drive type.

Top module: `ide_dma_chunk_seq`

## Requirements
- R1: After reset the sequencer is disarmed (`active_o`=0), `remaining_o` and `index_o` are 0, `st_valid_o` is 0 and `chunk_ready_o` is 1.
- R2: A start pulse taken while idle arms the sequencer. It sets `index_o` to 0 and clears `ready_seek_o`. It loads `remaining_o` with `start_pkt_bytes_i` when `start_optical_i`=1, or with `start_nsect_i`×512 otherwise.
- R3: A chunk accepted while disarmed gives a one-cycle `chunk_skip_o`, no `chunk_end_o`, no storage request, and no change to the counters.
- R4: A chunk evaluated while armed with `remaining_o` ≤ 0 (signed) ends the transfer. A disk pulses `drive_irq_o` and sets `ready_seek_o`, which holds until the next start. An optical drive pulses `cmd_ok_o`. In both cases `active_o` clears and `chunk_end_o` pulses.
- R5: A zero-length chunk evaluated while armed with `remaining_o` > 0 pulses only `chunk_end_o` and leaves the counters unchanged.
- R6: A block request carries `st_addr_o` = chunk address and `st_len_o` = chunk length. Its `st_offset_o` is (start sector << 9) + index for a disk, or (start LBA << 11) + index for an optical drive. `st_op_o` is 0 for read, 1 for write and 2 for trim. A disk takes this code from `start_cmd_i`. An optical drive always uses 0.
- R7: When a block request is issued, `remaining_o` falls by the chunk length and `index_o` rises by it. After a clean done, the chunk is evaluated again with length 0, so the transfer either completes as in R4 or the chunk ends as in R5.
- R8: An optical transfer whose start LBA is all ones issues one request with `st_op_o`=3 (buffer copy) and length min(remaining, chunk length). `remaining_o` becomes that minimum. A clean done then pulses `cmd_ok_o` with `chunk_end_o` and clears `active_o`.
- R9: A done with `st_err_i`=1 pulses `dma_err_o` (disk) or `io_err_o` (optical) together with `chunk_end_o`, and clears `active_o`.
- R10: A disk transfer started with command code 3 pulses `bad_cmd_o` and `chunk_end_o` on its first nonempty chunk, issues no request, and clears `active_o`.
- R11: While `st_valid_o`=1 and `st_ready_i`=0, the request stays valid and its offset and length do not change.
- R12: Each of the event outputs (`chunk_skip_o`, `cmd_ok_o`, `drive_irq_o`, `dma_err_o`, `io_err_o`, `bad_cmd_o`) lasts one cycle. At most one of them is high in any cycle. `active_o` is low whenever a completion or error event shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Arm a new transfer (taken only while idle) |
| start_optical_i | input | 1 | 1 = optical packet drive, 0 = hard disk |
| start_cmd_i | input | 2 | Disk command: 0 read, 1 write, 2 trim, 3 illegal |
| start_nsect_i | input | NSECT_W | Disk sector count |
| start_pkt_bytes_i | input | CNT_W | Optical packet transfer size in bytes |
| start_sector_i | input | SECT_W | Disk start sector |
| start_lba_i | input | LBA_W | Optical start block (all ones = non-block data) |
| chunk_valid_i | input | 1 | Chunk offered by the DMA engine |
| chunk_ready_o | output | 1 | Sequencer idle and able to take a chunk |
| chunk_addr_i | input | ADDR_W | Chunk memory address |
| chunk_len_i | input | CNT_W | Chunk length in bytes |
| chunk_end_o | output | 1 | Chunk finished pulse |
| chunk_skip_o | output | 1 | Chunk not processed, wait for restart |
| st_valid_o | output | 1 | Storage request valid |
| st_ready_i | input | 1 | Storage request accepted |
| st_op_o | output | 2 | 0 read, 1 write, 2 trim, 3 buffer copy |
| st_offset_o | output | OFF_W | Medium byte offset |
| st_addr_o | output | ADDR_W | Memory address |
| st_len_o | output | CNT_W | Byte count |
| st_done_i | input | 1 | Storage operation finished |
| st_err_i | input | 1 | Storage operation failed (with done) |
| active_o | output | 1 | Transfer armed |
| remaining_o | output | CNT_W | Signed bytes still owed |
| index_o | output | CNT_W | Bytes issued so far |
| ready_seek_o | output | 1 | Disk ready-and-seek status after completion |
| drive_irq_o | output | 1 | Disk completion interrupt pulse |
| cmd_ok_o | output | 1 | Optical command OK pulse |
| dma_err_o | output | 1 | Disk DMA error pulse |
| io_err_o | output | 1 | Optical I/O error pulse |
| bad_cmd_o | output | 1 | Illegal disk command pulse |

## Verification
The assertions check properties that must hold on every cycle. A stalled request must keep its offset and length. Issuing a request must preserve the sum of remaining and index. No request may exist while the sequencer is disarmed. Event pulses must not overlap, and an ending event must always coincide with a disarmed sequencer. Other behaviours can only be shown by the bench's scenarios, because they depend on arithmetic across a whole transfer. These include the exact offset shifts for each drive type and the point at which a transfer completes for each mix of sector count and chunk size. They also include the clamped length of non-block copies, the choice of error kind, and the dropping of chunks once a transfer has ended.

// File: rtl/ide_seq_pkg.sv
// Shared types for the IDE DMA chunk sequencer.
// Assumes nothing beyond the encodings fixed here.
package ide_seq_pkg;

    // Storage operation codes; disk commands share codes 0..2, code 3 is illegal for a disk
    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_TRIM    = 2'd2,
        OP_BUFCOPY = 2'd3
    } st_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EVAL,
        S_REQ,
        S_WAIT
    } seq_state_e;

    // Outcome of evaluating the current chunk
    typedef enum logic [2:0] {
        D_SKIP,
        D_DONE,
        D_EMPTY,
        D_COPY,
        D_BAD,
        D_ISSUE
    } seq_decide_e;

endpackage

// File: rtl/ide_seq_counters.sv
// Remaining / index counters for one transfer.
// Load takes priority. Advance moves bytes from remaining to index. Trim overwrites
// remaining (used by the non-block copy). Remaining is signed so that the
// "nothing owed" test is a signed compare against zero.
module ide_seq_counters #(
    parameter int CNT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [CNT_W-1:0]        load_val_i,
    input  logic                    adv_i,
    input  logic [CNT_W-1:0]        adv_len_i,
    input  logic                    trim_i,
    input  logic [CNT_W-1:0]        trim_val_i,
    output logic signed [CNT_W-1:0] rem_o,
    output logic [CNT_W-1:0]        idx_o
);

    logic signed [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0]        idx_q;

    // Counter update: reset, load, advance or trim
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            rem_q <= $signed(load_val_i);
            idx_q <= '0;
        end else if (adv_i) begin
            rem_q <= rem_q - $signed(adv_len_i);
            idx_q <= idx_q + adv_len_i;
        end else if (trim_i) begin
            rem_q <= $signed(trim_val_i);
        end
    end

    assign rem_o = rem_q;
    assign idx_o = idx_q;

    // Issuing a chunk moves bytes between the counters without creating or losing any
    assert_sum_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> ($unsigned(rem_q) + idx_q) == $past($unsigned(rem_q) + idx_q));

endmodule

// File: rtl/ide_seq_offset.sv
// Medium byte offset former.
// offset = (base << shift) + index. The base is the start sector with a 512-byte
// shift for a disk, or the start LBA with a 2048-byte shift for an optical drive.
// Assumes OFF_W is wide enough for both shifted bases.
module ide_seq_offset #(
    parameter int CNT_W      = 32,
    parameter int SECT_W     = 28,
    parameter int LBA_W      = 32,
    parameter int OFF_W      = 48,
    parameter int DISK_SHIFT = 9,
    parameter int OPT_SHIFT  = 11
) (
    input  logic              optical_i,
    input  logic [SECT_W-1:0] sector_i,
    input  logic [LBA_W-1:0]  lba_i,
    input  logic [CNT_W-1:0]  idx_i,
    output logic [OFF_W-1:0]  offset_o
);

    logic [OFF_W-1:0] disk_base;
    logic [OFF_W-1:0] opt_base;

    // Pick the shifted base for the drive type and add the running index
    always_comb begin
        disk_base = OFF_W'(sector_i) << DISK_SHIFT;
        opt_base  = OFF_W'(lba_i) << OPT_SHIFT;
        offset_o  = (optical_i ? opt_base : disk_base) + OFF_W'(idx_i);
    end

endmodule

// File: rtl/ide_seq_ctrl.sv
// Chunk sequencing FSM.
// IDLE takes a chunk, EVAL decides its outcome, REQ offers the storage request,
// and WAIT waits for storage done. A clean block done returns to EVAL with a zero
// length, so completion is detected in the same chunk. The start pulse is taken
// only in IDLE. Event outputs are registered one-cycle pulses.
module ide_seq_ctrl
    import ide_seq_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 32,
    parameter int SECT_W = 28,
    parameter int LBA_W  = 32,
    parameter int OFF_W  = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    start_optical_i,
    input  logic [1:0]              start_cmd_i,
    input  logic [SECT_W-1:0]       start_sector_i,
    input  logic [LBA_W-1:0]        start_lba_i,
    input  logic                    chunk_valid_i,
    output logic                    chunk_ready_o,
    input  logic [ADDR_W-1:0]       chunk_addr_i,
    input  logic [CNT_W-1:0]        chunk_len_i,
    output logic                    chunk_end_o,
    output logic                    chunk_skip_o,
    output logic                    st_valid_o,
    input  logic                    st_ready_i,
    output logic [1:0]              st_op_o,
    output logic [OFF_W-1:0]        st_offset_o,
    output logic [ADDR_W-1:0]       st_addr_o,
    output logic [CNT_W-1:0]        st_len_o,
    input  logic                    st_done_i,
    input  logic                    st_err_i,
    input  logic signed [CNT_W-1:0] rem_i,
    input  logic [OFF_W-1:0]        offset_i,
    output logic                    cnt_load_o,
    output logic                    cnt_adv_o,
    output logic [CNT_W-1:0]        cnt_adv_len_o,
    output logic                    cnt_trim_o,
    output logic [CNT_W-1:0]        cnt_trim_val_o,
    output logic                    x_optical_o,
    output logic [SECT_W-1:0]       x_sector_o,
    output logic [LBA_W-1:0]        x_lba_o,
    output logic                    active_o,
    output logic                    ready_seek_o,
    output logic                    drive_irq_o,
    output logic                    cmd_ok_o,
    output logic                    dma_err_o,
    output logic                    io_err_o,
    output logic                    bad_cmd_o
);

    seq_state_e        state_q;
    seq_decide_e       decide;
    st_op_e            op_q;
    logic              active_q, opt_q, rs_q;
    logic [1:0]        cmd_q;
    logic [SECT_W-1:0] sector_q;
    logic [LBA_W-1:0]  lba_q;
    logic [CNT_W-1:0]  cur_len_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [OFF_W-1:0]  off_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  len_q;
    logic              end_q, skip_q, irq_q, ok_q, derr_q, ierr_q, bad_q;
    logic              take_start, nonblock;
    logic [CNT_W-1:0]  copy_len;

    assign take_start = start_i && (state_q == S_IDLE);
    assign nonblock   = opt_q && (&lba_q);
    assign copy_len   = ($signed(cur_len_q) < rem_i) ? cur_len_q : $unsigned(rem_i);

    // Evaluation priority: disarmed, nothing owed, empty chunk, non-block copy, illegal, issue
    always_comb begin
        if (!active_q)                    decide = D_SKIP;
        else if (rem_i <= 0)              decide = D_DONE;
        else if (cur_len_q == '0)         decide = D_EMPTY;
        else if (nonblock)                decide = D_COPY;
        else if (!opt_q && cmd_q == 2'd3) decide = D_BAD;
        else                              decide = D_ISSUE;
    end

    // Counter controls derived from the evaluation outcome
    assign cnt_load_o     = take_start;
    assign cnt_adv_o      = (state_q == S_EVAL) && (decide == D_ISSUE);
    assign cnt_adv_len_o  = cur_len_q;
    assign cnt_trim_o     = (state_q == S_EVAL) && (decide == D_COPY);
    assign cnt_trim_val_o = copy_len;

    // Sequencer state, transfer parameters, request fields and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            active_q   <= 1'b0;
            opt_q      <= 1'b0;
            cmd_q      <= 2'd0;
            sector_q   <= '0;
            lba_q      <= '0;
            rs_q       <= 1'b0;
            cur_len_q  <= '0;
            cur_addr_q <= '0;
            op_q       <= OP_READ;
            off_q      <= '0;
            addr_q     <= '0;
            len_q      <= '0;
            end_q      <= 1'b0;
            skip_q     <= 1'b0;
            irq_q      <= 1'b0;
            ok_q       <= 1'b0;
            derr_q     <= 1'b0;
            ierr_q     <= 1'b0;
            bad_q      <= 1'b0;
        end else begin
            end_q  <= 1'b0;
            skip_q <= 1'b0;
            irq_q  <= 1'b0;
            ok_q   <= 1'b0;
            derr_q <= 1'b0;
            ierr_q <= 1'b0;
            bad_q  <= 1'b0;
            if (take_start) begin
                active_q <= 1'b1;
                opt_q    <= start_optical_i;
                cmd_q    <= start_cmd_i;
                sector_q <= start_sector_i;
                lba_q    <= start_lba_i;
                rs_q     <= 1'b0;
            end
            case (state_q)
                S_IDLE: begin
                    if (chunk_valid_i) begin
                        cur_len_q  <= chunk_len_i;
                        cur_addr_q <= chunk_addr_i;
                        state_q    <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    case (decide)
                        D_SKIP: begin
                            skip_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end
                        D_DONE: begin
                            if (opt_q) begin
                                ok_q <= 1'b1;
                            end else begin
                                irq_q <= 1'b1;
                                rs_q  <= 1'b1;
                            end
                            active_q <= 1'b0;
                            end_q    <= 1'b1;
                            state_q  <= S_IDLE;
                        end
                        D_EMPTY: begin
                            end_q   <= 1'b1;
                            state_q <= S_IDLE;
                        end
                        D_COPY: begin
                            op_q      <= OP_BUFCOPY;
                            off_q     <= offset_i;
                            addr_q    <= cur_addr_q;
                            len_q     <= copy_len;
                            cur_len_q <= '0;
                            state_q   <= S_REQ;
                        end
                        D_BAD: begin
                            bad_q    <= 1'b1;
                            active_q <= 1'b0;
                            end_q    <= 1'b1;
                            state_q  <= S_IDLE;
                        end
                        default: begin
                            op_q      <= opt_q ? OP_READ : st_op_e'(cmd_q);
                            off_q     <= offset_i;
                            addr_q    <= cur_addr_q;
                            len_q     <= cur_len_q;
                            cur_len_q <= '0;
                            state_q   <= S_REQ;
                        end
                    endcase
                end
                S_REQ: begin
                    if (st_ready_i) state_q <= S_WAIT;
                end
                default: begin
                    if (st_done_i) begin
                        if (st_err_i) begin
                            if (opt_q) ierr_q <= 1'b1;
                            else       derr_q <= 1'b1;
                            active_q <= 1'b0;
                            end_q    <= 1'b1;
                            state_q  <= S_IDLE;
                        end else if (op_q == OP_BUFCOPY) begin
                            ok_q     <= 1'b1;
                            active_q <= 1'b0;
                            end_q    <= 1'b1;
                            state_q  <= S_IDLE;
                        end else begin
                            state_q <= S_EVAL;
                        end
                    end
                end
            endcase
        end
    end

    assign chunk_ready_o = (state_q == S_IDLE);
    assign st_valid_o    = (state_q == S_REQ);
    assign st_op_o       = op_q;
    assign st_offset_o   = off_q;
    assign st_addr_o     = addr_q;
    assign st_len_o      = len_q;
    assign chunk_end_o   = end_q;
    assign chunk_skip_o  = skip_q;
    assign x_optical_o   = opt_q;
    assign x_sector_o    = sector_q;
    assign x_lba_o       = lba_q;
    assign active_o      = active_q;
    assign ready_seek_o  = rs_q;
    assign drive_irq_o   = irq_q;
    assign cmd_ok_o      = ok_q;
    assign dma_err_o     = derr_q;
    assign io_err_o      = ierr_q;
    assign bad_cmd_o     = bad_q;

    // A stalled request keeps its contents
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_o && !st_ready_i) |=> (st_valid_o && $stable(st_offset_o) && $stable(st_len_o)));

    // Requests exist only inside an armed transfer and never with zero length
    assert_req_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o |-> (active_o && st_len_o != '0));

    // Event pulses never overlap
    assert_one_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chunk_skip_o, cmd_ok_o, drive_irq_o, dma_err_o, io_err_o, bad_cmd_o}));

    // Ending events coincide with a disarmed sequencer
    assert_end_disarms_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok_o || drive_irq_o || dma_err_o || io_err_o || bad_cmd_o) |-> !active_o);

    // A dropped chunk is only reported while disarmed, never with chunk_end
    assert_skip_disarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_skip_o |-> (!active_o && !chunk_end_o));

    // Completion or error pulses last a single cycle
    assert_pulse_short_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_end_o || chunk_skip_o) |=> !(chunk_end_o || chunk_skip_o));

endmodule

// File: rtl/ide_dma_chunk_seq.sv
// Top of the IDE DMA chunk transfer sequencer.
// Ties the FSM, the counters and the offset former together and forms the
// counter load value. Assumes NSECT_W + DISK_SHIFT <= CNT_W.
module ide_dma_chunk_seq #(
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 32,
    parameter int NSECT_W    = 16,
    parameter int SECT_W     = 28,
    parameter int LBA_W      = 32,
    parameter int OFF_W      = 48,
    parameter int DISK_SHIFT = 9,
    parameter int OPT_SHIFT  = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     start_optical_i,
    input  logic [1:0]               start_cmd_i,
    input  logic [NSECT_W-1:0]       start_nsect_i,
    input  logic [CNT_W-1:0]         start_pkt_bytes_i,
    input  logic [SECT_W-1:0]        start_sector_i,
    input  logic [LBA_W-1:0]         start_lba_i,
    input  logic                     chunk_valid_i,
    output logic                     chunk_ready_o,
    input  logic [ADDR_W-1:0]        chunk_addr_i,
    input  logic [CNT_W-1:0]         chunk_len_i,
    output logic                     chunk_end_o,
    output logic                     chunk_skip_o,
    output logic                     st_valid_o,
    input  logic                     st_ready_i,
    output logic [1:0]               st_op_o,
    output logic [OFF_W-1:0]         st_offset_o,
    output logic [ADDR_W-1:0]        st_addr_o,
    output logic [CNT_W-1:0]         st_len_o,
    input  logic                     st_done_i,
    input  logic                     st_err_i,
    output logic                     active_o,
    output logic signed [CNT_W-1:0]  remaining_o,
    output logic [CNT_W-1:0]         index_o,
    output logic                     ready_seek_o,
    output logic                     drive_irq_o,
    output logic                     cmd_ok_o,
    output logic                     dma_err_o,
    output logic                     io_err_o,
    output logic                     bad_cmd_o
);

    localparam int PAD_W = CNT_W - NSECT_W;

    logic              cnt_load, cnt_adv, cnt_trim;
    logic [CNT_W-1:0]  cnt_adv_len, cnt_trim_val, load_val;
    logic              x_opt;
    logic [SECT_W-1:0] x_sector;
    logic [LBA_W-1:0]  x_lba;
    logic [OFF_W-1:0]  offset;

    // Byte count owed at start: packet size, or sectors times the sector size
    always_comb begin
        if (start_optical_i) load_val = start_pkt_bytes_i;
        else                 load_val = {{PAD_W{1'b0}}, start_nsect_i} << DISK_SHIFT;
    end

    ide_seq_ctrl #(
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W),
        .SECT_W(SECT_W),
        .LBA_W (LBA_W),
        .OFF_W (OFF_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .start_optical_i(start_optical_i),
        .start_cmd_i    (start_cmd_i),
        .start_sector_i (start_sector_i),
        .start_lba_i    (start_lba_i),
        .chunk_valid_i  (chunk_valid_i),
        .chunk_ready_o  (chunk_ready_o),
        .chunk_addr_i   (chunk_addr_i),
        .chunk_len_i    (chunk_len_i),
        .chunk_end_o    (chunk_end_o),
        .chunk_skip_o   (chunk_skip_o),
        .st_valid_o     (st_valid_o),
        .st_ready_i     (st_ready_i),
        .st_op_o        (st_op_o),
        .st_offset_o    (st_offset_o),
        .st_addr_o      (st_addr_o),
        .st_len_o       (st_len_o),
        .st_done_i      (st_done_i),
        .st_err_i       (st_err_i),
        .rem_i          (remaining_o),
        .offset_i       (offset),
        .cnt_load_o     (cnt_load),
        .cnt_adv_o      (cnt_adv),
        .cnt_adv_len_o  (cnt_adv_len),
        .cnt_trim_o     (cnt_trim),
        .cnt_trim_val_o (cnt_trim_val),
        .x_optical_o    (x_opt),
        .x_sector_o     (x_sector),
        .x_lba_o        (x_lba),
        .active_o       (active_o),
        .ready_seek_o   (ready_seek_o),
        .drive_irq_o    (drive_irq_o),
        .cmd_ok_o       (cmd_ok_o),
        .dma_err_o      (dma_err_o),
        .io_err_o       (io_err_o),
        .bad_cmd_o      (bad_cmd_o)
    );

    ide_seq_counters #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cnt_load),
        .load_val_i(load_val),
        .adv_i     (cnt_adv),
        .adv_len_i (cnt_adv_len),
        .trim_i    (cnt_trim),
        .trim_val_i(cnt_trim_val),
        .rem_o     (remaining_o),
        .idx_o     (index_o)
    );

    ide_seq_offset #(
        .CNT_W     (CNT_W),
        .SECT_W    (SECT_W),
        .LBA_W     (LBA_W),
        .OFF_W     (OFF_W),
        .DISK_SHIFT(DISK_SHIFT),
        .OPT_SHIFT (OPT_SHIFT)
    ) u_off (
        .optical_i(x_opt),
        .sector_i (x_sector),
        .lba_i    (x_lba),
        .idx_i    (index_o),
        .offset_o (offset)
    );

endmodule

// File: tb/ide_dma_chunk_seq_test.sv
`timescale 1ns/1ps
module ide_dma_chunk_seq_test;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0, start_optical_i = 1'b0;
    logic [1:0]         start_cmd_i = '0;
    logic [15:0]        start_nsect_i = '0;
    logic [31:0]        start_pkt_bytes_i = '0;
    logic [27:0]        start_sector_i = '0;
    logic [31:0]        start_lba_i = '0;
    logic               chunk_valid_i = 1'b0;
    logic               chunk_ready_o;
    logic [31:0]        chunk_addr_i = '0, chunk_len_i = '0;
    logic               chunk_end_o, chunk_skip_o;
    logic               st_valid_o;
    logic               st_ready_i = 1'b0;
    logic [1:0]         st_op_o;
    logic [47:0]        st_offset_o;
    logic [31:0]        st_addr_o, st_len_o;
    logic               st_done_i = 1'b0, st_err_i = 1'b0;
    logic               active_o;
    logic signed [31:0] remaining_o;
    logic [31:0]        index_o;
    logic               ready_seek_o, drive_irq_o, cmd_ok_o, dma_err_o, io_err_o, bad_cmd_o;

    int tests = 0;
    int fails = 0;

    // Transfer model kept by the bench
    int          m_rem;
    int unsigned m_idx;
    bit          m_act, m_opt, m_rs;
    logic [1:0]  m_cmd;
    logic [27:0] m_sec;
    logic [31:0] m_lba;

    always #10 clk = ~clk;

    ide_dma_chunk_seq uut (.*);

    task automatic chk(string tag, longint act, longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic start_xfer(bit opt, logic [1:0] cmd, int nsect, int pkt,
                              logic [27:0] sec, logic [31:0] lba);
        @(negedge clk);
        start_i = 1'b1; start_optical_i = opt; start_cmd_i = cmd;
        start_nsect_i = 16'(nsect); start_pkt_bytes_i = 32'(pkt);
        start_sector_i = sec; start_lba_i = lba;
        @(negedge clk);
        start_i = 1'b0;
        m_opt = opt; m_cmd = cmd; m_sec = sec; m_lba = lba;
        m_rem = opt ? pkt : nsect * 512;
        m_idx = 0; m_act = 1'b1; m_rs = 1'b0;
        // R2: armed with the loaded byte count and a cleared index
        chk("R2 remaining", longint'(remaining_o), m_rem);
        chk("R2 index", index_o, 0);
        chk("R2 active", active_o, 1);
        chk("R2 ready_seek", ready_seek_o, 0);
    endtask

    task automatic do_chunk(logic [31:0] addr, int unsigned len, bit err, int rdly);
        bit e_skip = 0, e_ok = 0, e_irq = 0, e_derr = 0, e_ierr = 0, e_bad = 0, e_req = 0;
        int e_op = 0;
        longint e_off = 0, e_len = 0;
        string t;
        bit g_skip = 0, g_end = 0, g_ok = 0, g_irq = 0, g_derr = 0, g_ierr = 0, g_bad = 0;
        int nreq = 0;
        longint g_op = 0, g_off = 0, g_addr = 0, g_len = 0;
        // Expected outcome from the requirements
        if (!m_act) begin
            e_skip = 1; t = "R3";
        end else if (m_rem <= 0) begin
            t = "R4";
            if (m_opt) e_ok = 1; else begin e_irq = 1; m_rs = 1; end
            m_act = 0;
        end else if (len == 0) begin
            t = "R5";
        end else if (m_opt && m_lba == 32'hFFFF_FFFF) begin
            t = "R8"; e_req = 1; e_op = 3;
            e_len = (int'(len) < m_rem) ? len : m_rem;
            m_rem = int'(e_len);
            if (err) begin e_ierr = 1; t = "R9"; end else e_ok = 1;
            m_act = 0;
        end else if (!m_opt && m_cmd == 2'd3) begin
            t = "R10"; e_bad = 1; m_act = 0;
        end else begin
            t = "R7"; e_req = 1;
            e_op = m_opt ? 0 : int'(m_cmd);
            e_off = (m_opt ? (longint'(m_lba) << 11) : (longint'(m_sec) << 9)) + longint'(m_idx);
            e_len = len;
            m_rem = m_rem - int'(len);
            m_idx = m_idx + len;
            if (err) begin
                t = "R9"; m_act = 0;
                if (m_opt) e_ierr = 1; else e_derr = 1;
            end else if (m_rem <= 0) begin
                if (m_opt) e_ok = 1; else begin e_irq = 1; m_rs = 1; end
                m_act = 0;
            end
        end
        // Offer the chunk while idle
        @(negedge clk);
        chunk_valid_i = 1'b1; chunk_addr_i = addr; chunk_len_i = len;
        @(negedge clk);
        chunk_valid_i = 1'b0;
        for (int c = 0; c < 80; c++) begin
            if (chunk_end_o || chunk_skip_o) begin
                g_skip = chunk_skip_o; g_end = chunk_end_o; g_ok = cmd_ok_o; g_irq = drive_irq_o;
                g_derr = dma_err_o; g_ierr = io_err_o; g_bad = bad_cmd_o;
                break;
            end
            if (st_valid_o) begin
                g_op = st_op_o; g_off = st_offset_o; g_addr = st_addr_o; g_len = st_len_o;
                for (int w = 0; w < rdly; w++) begin
                    @(negedge clk);
                    // R11: stalled request holds
                    chk("R11 hold", {st_valid_o, st_offset_o == g_off[47:0], st_len_o == g_len[31:0]}, 3'b111);
                end
                st_ready_i = 1'b1;
                nreq++;
                @(negedge clk);
                st_ready_i = 1'b0; st_done_i = 1'b1; st_err_i = err;
                @(negedge clk);
                st_done_i = 1'b0; st_err_i = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk({t, " events"}, {g_skip, g_end, g_ok, g_irq, g_derr, g_ierr, g_bad},
            {e_skip, !e_skip, e_ok, e_irq, e_derr, e_ierr, e_bad});
        chk({t, " request count"}, nreq, e_req);
        if (e_req && nreq == 1) begin
            chk(e_op == 3 ? "R8 op" : "R6 op", g_op, e_op);
            chk(e_op == 3 ? "R8 len" : "R6 len", g_len, e_len);
            chk("R6 addr", g_addr, addr);
            if (e_op != 3) chk("R6 offset", g_off, e_off);
        end
        chk({t, " remaining"}, longint'(remaining_o), m_rem);
        chk({t, " index"}, index_o, m_idx);
        chk({t, " active"}, active_o, m_act);
        chk("R4 ready_seek", ready_seek_o, m_rs);
        @(negedge clk);
        // R12: events were single-cycle pulses
        chk("R12 pulses low", {chunk_end_o, chunk_skip_o, cmd_ok_o, drive_irq_o, dma_err_o, io_err_o, bad_cmd_o}, 0);
    endtask

    initial begin
        int sizes[3];
        int pkts[4];
        sizes = '{256, 512, 1024};
        pkts  = '{0, 2048, 3000, 4096};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 active", active_o, 0);
        chk("R1 remaining", longint'(remaining_o), 0);
        chk("R1 index", index_o, 0);
        chk("R1 st_valid", st_valid_o, 0);
        chk("R1 chunk_ready", chunk_ready_o, 1);
        m_act = 0; m_rem = 0; m_idx = 0; m_rs = 0; m_opt = 0; m_cmd = 0; m_sec = 0; m_lba = 0;

        // R3: chunk before any start is dropped
        do_chunk(32'h100, 512, 0, 0);

        // Disk sweep: command x sector count x chunk size
        for (int cmd = 0; cmd < 3; cmd++)
            for (int ns = 0; ns < 4; ns++)
                for (int s = 0; s < 3; s++) begin
                    start_xfer(0, 2'(cmd), ns, 0, 28'(cmd * 100 + ns * 7 + 3), 0);
                    for (int k = 0; k < 10; k++) begin
                        if (!m_act) break;
                        do_chunk(32'h1000 * k + 32'(ns), sizes[s], 0, k % 3);
                    end
                    do_chunk(32'h8000, 512, 0, 0);
                end

        // Optical sweep: packet size x chunk size
        for (int p = 0; p < 4; p++)
            for (int s = 1; s < 3; s++) begin
                start_xfer(1, 2'd1, 0, pkts[p], 0, 32'd7 + 32'(p));
                for (int k = 0; k < 10; k++) begin
                    if (!m_act) break;
                    do_chunk(32'h2000 + 32'h40 * k, sizes[s] * 2, 0, k % 2);
                end
                do_chunk(32'h9000, 64, 0, 0);
            end

        // R5: zero-length chunk mid-transfer, then normal completion
        start_xfer(0, 2'd0, 2, 0, 28'd40, 0);
        do_chunk(32'h300, 0, 0, 0);
        do_chunk(32'h300, 512, 0, 1);
        do_chunk(32'h400, 0, 0, 0);
        do_chunk(32'h500, 512, 0, 0);

        // R8: non-block optical data, chunk shorter and longer than the data
        start_xfer(1, 2'd0, 0, 100, 0, 32'hFFFF_FFFF);
        do_chunk(32'h600, 64, 0, 2);
        start_xfer(1, 2'd0, 0, 100, 0, 32'hFFFF_FFFF);
        do_chunk(32'h700, 200, 0, 0);
        start_xfer(1, 2'd0, 0, 0, 0, 32'hFFFF_FFFF);
        do_chunk(32'h700, 200, 0, 0);

        // R9: errors on disk and optical
        start_xfer(0, 2'd1, 4, 0, 28'd9, 0);
        do_chunk(32'hA00, 512, 0, 0);
        do_chunk(32'hC00, 512, 1, 1);
        do_chunk(32'hE00, 512, 0, 0);
        start_xfer(1, 2'd0, 0, 4096, 0, 32'd12);
        do_chunk(32'hF00, 2048, 1, 0);
        start_xfer(1, 2'd0, 0, 100, 0, 32'hFFFF_FFFF);
        do_chunk(32'hF80, 50, 1, 0);

        // R10: illegal disk command
        start_xfer(0, 2'd3, 2, 0, 28'd5, 0);
        do_chunk(32'h1100, 0, 0, 0);
        do_chunk(32'h1200, 512, 0, 0);
        do_chunk(32'h1300, 512, 0, 0);

        finish_run();
    end

endmodule